// File: doc/BRIEF.md
# Prescaled Event Timer with Two-Step Compare Channels

This block is a 24-bit time base for a radio sequencer. A 3-bit prescale code divides the block clock, and the counter advances by one on each divided tick. It wraps from all ones to zero. A host reaches the block through a small register port: write and read strobes, an address, 16-bit data, and read data returned one cycle after the strobe. Through this port the host can load the current time, set a number of 24-bit absolute-time compare channels, and read back a coherent copy of the running count. A frame-start input copies the running count into a timestamp register.

Each compare channel takes its 24-bit value in two steps. A write to the channel's upper register stages the upper 8 bits and a disable bit, and the channel stops matching. A later write to the channel's lower register loads the full value. That write re-arms the channel unless the staged disable bit is set. Each channel runs a small state machine. In `CH_OFF` the channel never matches. In `CH_WAIT` an upper write has started and the channel waits for the lower write. In `CH_ARMED` the channel matches. The transitions are as follows:

- An upper write moves any state to `CH_WAIT`.
- A lower write moves to `CH_ARMED` when the disable bit is clear, and to `CH_OFF` when it is set.
- Reset enters `CH_OFF`.

In streaming mode, one channel (channel 1) ignores its 24-bit compare. Instead it compares a separate 16-bit value against the low 16 bits of the count. Every channel gives a one-cycle match pulse and a sticky flag. The flag stays set until the host pulses that channel's clear input.

Top module: `evt_timer`

Register addresses (5 bits):
- 0: control. Bits [2:0] hold the prescale code and bit 3 selects streaming mode.
- 1: time upper. Bits [7:0] hold count bits 23..16.
- 2: time lower 16 bits.
- 3: timestamp upper. Bits [7:0] hold stamp bits 23..16.
- 4: timestamp lower 16 bits.
- 5: short compare.
- 8+2k: channel k upper. Bits [7:0] hold compare bits 23..16 and bit 15 is the disable bit.
- 9+2k: channel k lower.

## Requirements
- R1: The count is 24 bits wide and reads 0 after reset. Each prescaled tick adds one, and the count wraps from 0xFFFFFF to 0x000000. Between ticks the count holds.
- R2: With prescale code s (control bits [2:0]), a tick occurs every 2^s block clocks. Writing the control register restarts the divider, so the first increment lands on the 2^s-th clock edge after the write edge. The code resets to 7.
- R3: A write to time-upper stages bits [7:0]. A write to time-lower loads the count with {staged, data}. A load takes priority over a tick in the same cycle.
- R4: A read strobe returns data on rdata in the next cycle, and rdata holds otherwise. Reading time-upper returns count bits 23..16 in [7:0] and freezes count bits 15..0. The next time-lower read returns that frozen value, even if the count has moved.
- R5: A channel-upper write (bits [7:0] upper, bit 15 disable) disarms the channel. A channel-lower write loads the 24-bit compare and arms the channel, or leaves it off if the disable bit is 1. After reset the compare lower reads 0xFFFF, the upper reads 0x0000, and the channel is off.
- R6: An armed channel pulses its match output for exactly one cycle, the cycle in which a tick first makes the count equal its compare value. A host load that sets the count to the compare value produces no pulse.
- R7: With control bit 3 set, channel 1 matches when a tick makes count bits 15..0 equal the short compare register (reset 0xFFFF). Its 24-bit compare is then ignored.
- R8: A frame-start pulse copies the count into the timestamp register. Counting continues without interruption.
- R9: A match sets that channel's flag. The flag holds until the channel's clear input is pulsed.
- R10: During reset, rdata, match pulses and match flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the prescaler base |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| frame_start | input | 1 | Receive frame start; captures the timestamp |
| match_clr | input | 3 | Per-channel flag clear |
| match_pulse | output | 3 | Per-channel one-cycle match pulse |
| match_flag | output | 3 | Per-channel sticky match flag |

## Verification
The hardest case to reach is the window between the two halves of a compare write. In that window the channel must stay silent while the count passes its old target, and it must then fire on the exact tick after the lower write lands. The stimulus loads a known time at prescale code 0, writes only the upper half, and runs the count past the old target. It then writes the lower half and checks that the pulse arrives on the cycle counted from that write. The same cycle counting is used for the streaming case. There the 24-bit target of channel 1 lies before the short target, so a pulse at the wrong cycle shows which compare was used.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // register map (5-bit address space)
    localparam int unsigned A_CTRL     = 0;
    localparam int unsigned A_TIME_HI  = 1;
    localparam int unsigned A_TIME_LO  = 2;
    localparam int unsigned A_STAMP_HI = 3;
    localparam int unsigned A_STAMP_LO = 4;
    localparam int unsigned A_SHORT    = 5;
    localparam int unsigned A_CMP_BASE = 8;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_WAIT,
        CH_ARMED
    } chan_state_e;

endpackage

// File: rtl/evt_prescale.sv
module evt_prescale #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = (DIV_W'(1) << sel) - DIV_W'(1);
        tick = (div_q & mask) == mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else              div_q <= div_q + DIV_W'(1);
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> div_q == '0); // R2

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count_o <= '0;
        else if (load) count_o <= load_val;
        else if (tick) count_o <= count_o + CNT_W'(1);
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(count_o)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick) |=> count_o == $past(count_o) + CNT_W'(1)); // R1
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_o == $past(load_val)); // R3

endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan
    import evt_pkg::*;
#(
    parameter int unsigned CNT_W = 24,
    parameter int unsigned LO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [LO_W-1:0]  wdata,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic             short_mode,
    input  logic [LO_W-1:0]  short_val,
    input  logic             clr,
    output logic             match_o,
    output logic             flag_o,
    output logic [LO_W-1:0]  rd_hi,
    output logic [LO_W-1:0]  rd_lo
);
    localparam int unsigned UP_W  = CNT_W - LO_W;
    localparam int unsigned PAD_W = LO_W - 1 - UP_W;

    chan_state_e      state_q, state_d;
    logic [UP_W-1:0]  up_stage_q;
    logic             dis_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] nxt;
    logic             hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (hi_wr)               state_d = CH_WAIT;
                else if (lo_wr && !dis_q) state_d = CH_ARMED;
            end
            CH_WAIT: begin
                if (lo_wr) state_d = dis_q ? CH_OFF : CH_ARMED;
            end
            CH_ARMED: begin
                if (hi_wr)               state_d = CH_WAIT;
                else if (lo_wr && dis_q) state_d = CH_OFF;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // compare value staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_stage_q <= '0;
            dis_q      <= 1'b0;
            cmp_q      <= {{UP_W{1'b0}}, {LO_W{1'b1}}};
        end else if (hi_wr) begin
            up_stage_q <= wdata[UP_W-1:0];
            dis_q      <= wdata[LO_W-1];
        end else if (lo_wr) begin
            cmp_q <= {up_stage_q, wdata};
        end
    end

    // look-ahead: match on the tick that makes count equal the target
    always_comb begin
        nxt = count + CNT_W'(1);
        if (short_mode) hit = tick && !load && (nxt[LO_W-1:0] == short_val);
        else            hit = tick && !load && (state_q == CH_ARMED) && (nxt == cmp_q);
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            flag_o  <= 1'b0;
        end else begin
            match_o <= hit;
            if (hit)      flag_o <= 1'b1;
            else if (clr) flag_o <= 1'b0;
        end
    end

    assign rd_hi = {dis_q, {PAD_W{1'b0}}, cmp_q[CNT_W-1:LO_W]};
    assign rd_lo = cmp_q[LO_W-1:0];

    AST_HI_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> state_q == CH_WAIT); // R5
    AST_LOAD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !match_o); // R6
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> flag_o); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o); // R9

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int unsigned CNT_W     = 24,
    parameter int unsigned LO_W      = 16,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned NCH       = 3,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned STREAM_CH = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LO_W-1:0]   wdata,
    output logic [LO_W-1:0]   rdata,
    input  logic              frame_start,
    input  logic [NCH-1:0]    match_clr,
    output logic [NCH-1:0]    match_pulse,
    output logic [NCH-1:0]    match_flag
);
    localparam int unsigned UP_W  = CNT_W - LO_W;
    localparam int unsigned CTL_PAD = LO_W - SEL_W - 1;
    localparam int unsigned UP_PAD  = LO_W - UP_W;

    logic [SEL_W-1:0] sel_q;
    logic             stream_q;
    logic [UP_W-1:0]  time_stage_q;
    logic [LO_W-1:0]  short_q;
    logic [LO_W-1:0]  snap_q;
    logic [CNT_W-1:0] stamp_q;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             ctrl_wr, load, snap_rd;
    logic [LO_W-1:0]  rd_mux;
    logic [LO_W-1:0]  ch_hi [NCH];
    logic [LO_W-1:0]  ch_lo [NCH];

    assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));
    assign load    = wr_en && (addr == ADDR_W'(A_TIME_LO));
    assign snap_rd = rd_en && (addr == ADDR_W'(A_TIME_HI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q        <= '1;
            stream_q     <= 1'b0;
            time_stage_q <= '0;
            short_q      <= '1;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_CTRL)) begin
                sel_q    <= wdata[SEL_W-1:0];
                stream_q <= wdata[SEL_W];
            end
            if (addr == ADDR_W'(A_TIME_HI)) time_stage_q <= wdata[UP_W-1:0];
            if (addr == ADDR_W'(A_SHORT))   short_q      <= wdata;
        end
    end

    evt_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_q),
        .restart (ctrl_wr),
        .tick    (tick)
    );

    evt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val ({time_stage_q, wdata}),
        .count_o  (count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q  <= '0;
            stamp_q <= '0;
        end else begin
            if (snap_rd)     snap_q  <= count[LO_W-1:0];
            if (frame_start) stamp_q <= count;
        end
    end

    for (genvar gk = 0; gk < NCH; gk++) begin : g_ch
        logic short_sel;
        assign short_sel = stream_q && (gk == STREAM_CH);

        evt_cmp_chan #(.CNT_W(CNT_W), .LO_W(LO_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .hi_wr      (wr_en && (addr == ADDR_W'(A_CMP_BASE + 2*gk))),
            .lo_wr      (wr_en && (addr == ADDR_W'(A_CMP_BASE + 2*gk + 1))),
            .wdata      (wdata),
            .tick       (tick),
            .load       (load),
            .count      (count),
            .short_mode (short_sel),
            .short_val  (short_q),
            .clr        (match_clr[gk]),
            .match_o    (match_pulse[gk]),
            .flag_o     (match_flag[gk]),
            .rd_hi      (ch_hi[gk]),
            .rd_lo      (ch_lo[gk])
        );
    end

    always_comb begin
        rd_mux = '0;
        if      (addr == ADDR_W'(A_CTRL))     rd_mux = {{CTL_PAD{1'b0}}, stream_q, sel_q};
        else if (addr == ADDR_W'(A_TIME_HI))  rd_mux = {{UP_PAD{1'b0}}, count[CNT_W-1:LO_W]};
        else if (addr == ADDR_W'(A_TIME_LO))  rd_mux = snap_q;
        else if (addr == ADDR_W'(A_STAMP_HI)) rd_mux = {{UP_PAD{1'b0}}, stamp_q[CNT_W-1:LO_W]};
        else if (addr == ADDR_W'(A_STAMP_LO)) rd_mux = stamp_q[LO_W-1:0];
        else if (addr == ADDR_W'(A_SHORT))    rd_mux = short_q;
        else begin
            for (int k = 0; k < NCH; k++) begin
                if (addr == ADDR_W'(A_CMP_BASE + 2*k))     rd_mux = ch_hi[k];
                if (addr == ADDR_W'(A_CMP_BASE + 2*k + 1)) rd_mux = ch_lo[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_STAMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> stamp_q == $past(count)); // R8
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_rd |=> $stable(snap_q)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R4

endmodule

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;

    localparam int A_CTRL = 0, A_THI = 1, A_TLO = 2, A_SHI = 3, A_SLO = 4, A_SHORT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        frame_start = 1'b0;
    logic [2:0]  match_clr = '0;
    logic [2:0]  match_pulse, match_flag;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    evt_timer u_evt_timer (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .frame_start (frame_start), .match_clr (match_clr),
        .match_pulse (match_pulse), .match_flag (match_flag)
    );

    // vectors: prescale code, loaded time, idle cycles, expected count at read
    localparam int NV = 6;
    localparam int          V_SEL  [NV] = '{0, 0, 2, 3, 7, 1};
    localparam logic [23:0] V_LOAD [NV] = '{24'h000000, 24'hFFFFFE, 24'h123456,
                                            24'h00FFFF, 24'h000100, 24'hABCDEF};
    localparam int          V_WAIT [NV] = '{10, 3, 12, 20, 130, 9};
    localparam logic [23:0] V_EXP  [NV] = '{24'h00000A, 24'h000001, 24'h123459,
                                            24'h010001, 24'h000101, 24'hABCDF3};

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic wr(input int a, input logic [15:0] d);
        wr_en = 1'b1; addr = 5'(a); wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        rd_en = 1'b1; addr = 5'(a);
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; d = rdata;
    endtask

    task automatic watch(input int ch, input int n, output int first, output int cnt);
        first = -1; cnt = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (match_pulse[ch]) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
    endtask

    task automatic load_time(input logic [23:0] t);
        wr(A_THI, {8'h00, t[23:16]});
        wr(A_TLO, t[15:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] d, lo;
        int first, cnt;

        repeat (3) @(negedge clk);
        chk("R10", "rdata in reset", 32'(rdata), 32'h0);
        chk("R10", "pulses in reset", 32'(match_pulse), 32'h0);
        chk("R10", "flags in reset", 32'(match_flag), 32'h0);
        rst_n = 1'b1;

        rd(A_THI, d); chk("R1", "count upper after reset", 32'(d), 32'h0);
        rd(A_TLO, d); chk("R1", "count lower after reset", 32'(d), 32'h0);
        rd(A_CTRL, d); chk("R2", "prescale code reset", 32'(d), 32'h7);
        rd(9, d);  chk("R5", "cmp0 lower reset", 32'(d), 32'hFFFF);
        rd(8, d);  chk("R5", "cmp0 upper reset", 32'(d), 32'h0);
        rd(A_SHORT, d); chk("R7", "short cmp reset", 32'(d), 32'hFFFF);
        rd(A_SLO, d); chk("R8", "stamp reset", 32'(d), 32'h0);

        // vector table: R1 R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            wr(A_CTRL, 16'(V_SEL[v]));
            load_time(V_LOAD[v]);
            repeat (V_WAIT[v]) @(negedge clk);
            rd(A_THI, d);
            rd(A_TLO, lo);
            chk("R2", $sformatf("vector %0d upper", v), 32'(d), 32'(V_EXP[v][23:16]));
            chk("R1", $sformatf("vector %0d lower", v), 32'(lo), 32'(V_EXP[v][15:0]));
        end

        // snapshot coherence: R4
        wr(A_CTRL, 16'h0000);
        load_time(24'h02FFFC);
        rd(A_THI, d);
        repeat (6) @(negedge clk);
        rd(A_TLO, lo);
        chk("R4", "snapshot upper", 32'(d), 32'h02);
        chk("R4", "snapshot lower frozen", 32'(lo), 32'hFFFC);

        // channel 0 match: R6 R9
        wr(A_CTRL, 16'h0000);
        load_time(24'h000010);
        wr(8, 16'h0000);
        wr(9, 16'h0020);
        watch(0, 40, first, cnt);
        chk("R6", "ch0 pulse cycle", 32'(first), 32'd14);
        chk("R6", "ch0 pulse count", 32'(cnt), 32'd1);
        chk("R9", "ch0 flag sticky", 32'(match_flag[0]), 32'h1);
        match_clr[0] = 1'b1; @(negedge clk); match_clr[0] = 1'b0;
        chk("R9", "ch0 flag cleared", 32'(match_flag[0]), 32'h0);

        // disable bit applied at lower write: R5
        wr(A_CTRL, 16'h0000);
        load_time(24'h000010);
        wr(8, 16'h8000);
        wr(9, 16'h0020);
        watch(0, 40, first, cnt);
        chk("R5", "disabled ch0 silent", 32'(cnt), 32'd0);
        chk("R5", "disabled ch0 flag", 32'(match_flag[0]), 32'h0);

        // upper write disarms until lower write: R5 R6
        wr(A_CTRL, 16'h0000);
        load_time(24'h000010);
        wr(8, 16'h0000);
        watch(0, 30, first, cnt);
        chk("R5", "pending ch0 silent", 32'(cnt), 32'd0);
        wr(9, 16'h0040);
        watch(0, 40, first, cnt);
        chk("R5", "re-armed ch0 pulse cycle", 32'(first), 32'd16);
        chk("R6", "re-armed ch0 single pulse", 32'(cnt), 32'd1);

        // host load onto target: R6
        wr(A_CTRL, 16'h0007);
        wr(12, 16'h0000);
        wr(13, 16'h0300);
        load_time(24'h000300);
        watch(2, 10, first, cnt);
        chk("R6", "load onto target silent", 32'(cnt), 32'd0);
        rd(A_THI, d); rd(A_TLO, lo);
        chk("R3", "loaded time", 32'({d[7:0], lo}), 32'h000300);

        // streaming short compare on channel 1: R7
        wr(A_CTRL, 16'h0007);
        load_time(24'h000000);
        wr(10, 16'h0005);
        wr(11, 16'h0025);
        wr(A_SHORT, 16'h0030);
        wr(A_CTRL, 16'h0008);
        load_time(24'h050020);
        watch(1, 40, first, cnt);
        chk("R7", "short pulse cycle", 32'(first), 32'd16);
        chk("R7", "short single pulse", 32'(cnt), 32'd1);

        // timestamp: R8
        wr(A_CTRL, 16'h0000);
        load_time(24'h00AB00);
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        rd(A_SHI, d); rd(A_SLO, lo);
        chk("R8", "stamp upper", 32'(d), 32'h0000);
        chk("R8", "stamp lower", 32'(lo), 32'hAB00);
        rd(A_THI, d); rd(A_TLO, lo);
        chk("R8", "count kept running", 32'({d[7:0], lo}), 32'h00AB03);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule